// File: doc/BRIEF.md
# PC-Indexed Stream Prefetch Table

This block watches cache accesses that arrive together with the program counter of the instruction that issued them. It keeps a small, fully associative table with one entry per instruction. Each entry holds the last address that instruction touched and a confidence counter. When an instruction keeps touching new addresses, its counter rises. Once confidence is high enough, every further move of that instruction produces a burst of four prefetch addresses. The burst continues along the stride the instruction just took.

Accesses are presented one per cycle on a valid-qualified input. The prefetch addresses come out of a small queue with a valid/ready handshake, so a downstream cache or request arbiter can take them at its own pace. The table uses least-recently-used replacement. It keeps no state beyond the tag, the last address and the counter of each entry.

Top module: `stream_pf_table`

## Requirements
- R1: After reset, `pf_valid` is 0 and every table entry is invalid. A PC trained before reset behaves as new afterwards.
- R2: An access with `acc_has_pc` = 0 is ignored completely. It changes no entry, no counter and no replacement order, and it produces no prefetch.
- R3: An access whose PC matches no valid entry takes the least-recently-used entry. That entry is tagged with the PC, records the access address and has its counter cleared. No prefetch is produced.
- R4: A hit whose address differs from the stored address increments that entry's counter. A burst is produced when the incremented counter is 4 or more. This is the fourth differing hit after allocation, and every differing hit after that.
- R5: A burst is four prefetches, leaving in order k = 1, 2, 3, 4 with address `acc_addr + delta*k` modulo 2^ADDR_W. Here delta = `acc_addr` minus the stored address, taken modulo 2^ADDR_W, so a downward stride gives descending addresses. Each prefetch carries the `acc_secure` value of the access that triggered it.
- R6: A hit at the same address as the one stored leaves the counter unchanged and produces no prefetch. Every hit replaces the stored address with the current one, so delta is always measured from the most recent access by that PC.
- R7: The table has 16 entries and is fully associative. A hit makes its entry most recently used. An allocation evicts the least recently used entry.
- R8: The counter is 3 bits wide and saturates at 7 instead of wrapping. Bursts therefore continue on every differing hit, however long the stream runs.
- R9: The output queue holds 4 addresses. A burst is written only when all four slots are free at the triggering edge; otherwise the whole burst is dropped. While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_has_pc | input | 1 | The access carries a program counter |
| acc_pc | input | PC_W | Program counter of the issuing instruction |
| acc_addr | input | ADDR_W | Accessed address |
| acc_secure | input | 1 | Security attribute of the access |
| pf_ready | input | 1 | Consumer takes the head prefetch this cycle |
| pf_valid | output | 1 | A prefetch address is available |
| pf_addr | output | ADDR_W | Head prefetch address |
| pf_secure | output | 1 | Security attribute of the head prefetch |

## Verification
The lookup, the counter update and the burst write all happen at the clock edge that samples the access. The first prefetch of a burst therefore appears on `pf_valid`/`pf_addr` one edge after the access, and each later one appears one edge after the previous one was accepted. The bench drives each access on a falling edge and removes it on the next falling edge. It samples the outputs on that second falling edge and then once per cycle, while `pf_ready` is held high. It checks that the queue is empty after the fourth prefetch. It also checks that the queue stays empty after every access that must not trigger a burst. In the back-pressure case `pf_ready` is held low. The outputs are then sampled on several successive falling edges to confirm that they hold, and the queue is drained afterwards to count exactly what was kept.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;

  // Address of the k-th prefetch of a burst, in 64-bit modular arithmetic.
  // The caller truncates the result to its own address width.
  function automatic logic [63:0] stride_target(input logic [63:0] base,
                                                input logic [63:0] step,
                                                input logic [63:0] k);
    return base + step * k;
  endfunction

  // Increment that stops at the ceiling instead of wrapping.
  function automatic logic [7:0] sat_inc(input logic [7:0] v,
                                         input logic [7:0] ceiling);
    return (v >= ceiling) ? ceiling : v + 8'd1;
  endfunction

endpackage

// File: rtl/pst_match.sv
module pst_match #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                             lookup_en,
  input  logic [PC_W-1:0]                  pc,
  input  logic [ENTRIES-1:0]               ent_valid,
  input  logic [ENTRIES-1:0][PC_W-1:0]     ent_tag,
  output logic [ENTRIES-1:0]               hit_vec,
  output logic                             hit,
  output logic [IDX_W-1:0]                 hit_idx
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = lookup_en && ent_valid[i] && (ent_tag[i] == pc);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pst_lru.sv
module pst_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  // Age 0 is most recently used and age ENTRIES-1 least recently used.
  // ENTRIES must be a power of two so that the ages form a permutation.
  logic [ENTRIES-1:0][IDX_W-1:0] age;
  logic [IDX_W-1:0]              touched_age;

  assign touched_age = age[touch_idx];

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)    age[i] <= '0;
        else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pst_burst_fifo.sv
module pst_burst_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4,
  parameter int BURST = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [BURST-1:0][W-1:0]     push_data,
  input  logic                        pop,
  output logic                        out_valid,
  output logic [W-1:0]                out_data,
  output logic                        room,
  output logic [CW-1:0]               count
);

  // DEPTH is a power of two so that the pointers wrap by themselves.
  logic [DEPTH-1:0][W-1:0] mem;
  logic [PW-1:0]           wr_ptr;
  logic [PW-1:0]           rd_ptr;
  logic                    do_pop;

  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign room      = (count <= CW'(DEPTH - BURST));
  assign do_pop    = pop && out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        for (int k = 0; k < BURST; k++) mem[wr_ptr + PW'(k)] <= push_data[k];
        wr_ptr <= wr_ptr + PW'(BURST);
      end
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (push ? CW'(BURST) : CW'(0)) - (do_pop ? CW'(1) : CW'(0));
    end
  end

endmodule

// File: rtl/stream_pf_table.sv
module stream_pf_table
  import stream_pf_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 3,
  parameter int THRESH     = 4,
  parameter int BURST      = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_has_pc,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              pf_secure
);

  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int FW      = ADDR_W + 1;
  localparam int FCW     = $clog2(FIFO_DEPTH + 1);

  // Table state
  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][PC_W-1:0]    ent_tag;
  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_addr;
  logic [ENTRIES-1:0][CNT_W-1:0]   ent_cnt;

  // Named events, also used by the checker
  logic                   lookup_en;
  logic [ENTRIES-1:0]     hit_vec;
  logic                   hit;
  logic [IDX_W-1:0]       hit_idx;
  logic [IDX_W-1:0]       victim_idx;
  logic [IDX_W-1:0]       touch_idx;
  logic [ADDR_W-1:0]      old_addr;
  logic [ADDR_W-1:0]      delta;
  logic                   addr_moved;
  logic [CNT_W-1:0]       cnt_next;
  logic                   burst_fire;
  logic                   burst_push;
  logic                   fifo_room;
  logic [FCW-1:0]         fifo_count;
  logic [BURST-1:0][FW-1:0] burst_data;
  logic [FW-1:0]          head;

  assign lookup_en = acc_valid && acc_has_pc;

  pst_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_match (
    .lookup_en (lookup_en),
    .pc        (acc_pc),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  assign touch_idx = hit ? hit_idx : victim_idx;

  pst_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (lookup_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  // Stride detection on a hit
  assign old_addr   = ent_addr[hit_idx];
  assign delta      = acc_addr - old_addr;
  assign addr_moved = hit && (acc_addr != old_addr);
  assign cnt_next   = CNT_W'(sat_inc(8'(ent_cnt[hit_idx]), 8'(CNT_MAX)));
  assign burst_fire = addr_moved && (int'(cnt_next) >= THRESH);
  assign burst_push = burst_fire && fifo_room;

  for (genvar k = 0; k < BURST; k++) begin : g_tgt
    assign burst_data[k] = {acc_secure,
                            ADDR_W'(stride_target(64'(acc_addr), 64'(delta), 64'(k + 1)))};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_tag   <= '0;
      ent_addr  <= '0;
      ent_cnt   <= '0;
    end else if (lookup_en) begin
      if (hit) begin
        ent_addr[hit_idx] <= acc_addr;
        if (addr_moved) ent_cnt[hit_idx] <= cnt_next;
      end else begin
        ent_valid[victim_idx] <= 1'b1;
        ent_tag[victim_idx]   <= acc_pc;
        ent_addr[victim_idx]  <= acc_addr;
        ent_cnt[victim_idx]   <= '0;
      end
    end
  end

  pst_burst_fifo #(.W(FW), .DEPTH(FIFO_DEPTH), .BURST(BURST)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (burst_push),
    .push_data (burst_data),
    .pop       (pf_ready),
    .out_valid (pf_valid),
    .out_data  (head),
    .room      (fifo_room),
    .count     (fifo_count)
  );

  assign pf_addr   = head[ADDR_W-1:0];
  assign pf_secure = head[ADDR_W];

endmodule

// File: rtl/stream_pf_table_chk.sv
module stream_pf_table_chk #(
  parameter int ENTRIES    = 16,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookup_en,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               burst_fire,
  input logic               burst_push,
  input logic [FCW-1:0]     fifo_count,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [ADDR_W-1:0]  pf_addr
);

  // R9
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= FCW'(FIFO_DEPTH));

  // R2
  nopc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_en |-> !burst_fire);

  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_en && (hit_vec == '0) |-> !burst_fire);

  // R7
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R5
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_push |=> pf_valid);

endmodule

bind stream_pf_table stream_pf_table_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lookup_en  (lookup_en),
  .hit_vec    (hit_vec),
  .burst_fire (burst_fire),
  .burst_push (burst_push),
  .fifo_count (fifo_count),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_addr    (pf_addr)
);

// File: tb/stream_pf_table_tb_top.sv
`timescale 1ns/1ps
module stream_pf_table_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_has_pc = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_secure = 1'b0;
  logic        pf_ready = 1'b1;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic        pf_secure;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stream_pf_table dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_has_pc(acc_has_pc),
    .acc_pc(acc_pc), .acc_addr(acc_addr), .acc_secure(acc_secure),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_secure(pf_secure)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // The access is sampled on the rising edge between the two falling edges.
  task automatic acc(input logic [31:0] pc, input logic [31:0] a,
                     input logic s, input logic has);
    @(negedge clk);
    acc_valid = 1'b1; acc_has_pc = has; acc_pc = pc; acc_addr = a; acc_secure = s;
    @(negedge clk);
    acc_valid = 1'b0; acc_has_pc = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    check(pf_valid == 1'b0, tag, 32'(pf_valid), 32'd0);
  endtask

  // Walk the stride from the trigger address; one prefetch per cycle.
  task automatic expect_burst(input string tag, input logic [31:0] a,
                              input logic [31:0] d, input logic s);
    logic [31:0] e;
    e = a;
    for (int k = 1; k <= 4; k++) begin
      e = e + d;
      check(pf_valid == 1'b1, tag, 32'(pf_valid), 32'd1);
      check(pf_addr == e, tag, pf_addr, e);
      check(pf_secure == s, tag, 32'(pf_secure), 32'(s));
      @(negedge clk);
    end
    expect_none(tag);
  endtask

  // Allocate, then three differing hits: the counter ends at 3.
  task automatic train3(input logic [31:0] pc, input logic [31:0] a0,
                        input logic [31:0] d, input string tag);
    acc(pc, a0, 1'b0, 1'b1);
    expect_none(tag);
    for (int k = 1; k <= 3; k++) begin
      acc(pc, a0 + d * k, 1'b0, 1'b1);
      expect_none(tag);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] strides [6];
    logic [31:0] a;
    strides[0] = 32'd4;  strides[1] = 32'd64;  strides[2] = -32'sd12;
    strides[3] = 32'd1;  strides[4] = 32'h0010_0000; strides[5] = -32'sd4096;

    do_reset();
    // R1: empty after reset
    expect_none("R1 reset");

    // R3: first access is a miss and produces nothing
    acc(32'h40, 32'h1000, 1'b0, 1'b1);
    expect_none("R3 alloc");

    // R4/R5: sweep of strides, each on its own PC
    for (int s = 0; s < 6; s++) begin
      train3(32'h200 + 32'(s) * 4, 32'h0800_0000, strides[s], "R4 below threshold");
      a = 32'h0800_0000 + strides[s] * 4;
      acc(32'h200 + 32'(s) * 4, a, s[0], 1'b1);
      expect_burst("R5 burst", a, strides[s], s[0]);
    end

    // R8: keep moving the last PC; the counter must not wrap
    a = 32'h0800_0000 + strides[5] * 4;
    for (int k = 0; k < 10; k++) begin
      a = a + strides[5];
      acc(32'h214, a, 1'b1, 1'b1);
      expect_burst("R8 saturate", a, strides[5], 1'b1);
    end

    // R6: same-address hit does not count; delta from latest address
    acc(32'h300, 32'h1000, 1'b0, 1'b1);
    acc(32'h300, 32'h1010, 1'b0, 1'b1); expect_none("R6");
    acc(32'h300, 32'h1010, 1'b0, 1'b1); expect_none("R6 same addr");
    acc(32'h300, 32'h1020, 1'b0, 1'b1); expect_none("R6");
    acc(32'h300, 32'h1030, 1'b0, 1'b1); expect_none("R6 count held");
    acc(32'h300, 32'h1050, 1'b1, 1'b1);
    expect_burst("R6 delta", 32'h1050, 32'h20, 1'b1);

    // R2: access without PC is ignored
    train3(32'h400, 32'h2000, 32'h10, "R2 train");
    acc(32'h400, 32'h5000, 1'b0, 1'b0);
    expect_none("R2 no pc");
    acc(32'h400, 32'h2040, 1'b0, 1'b1);
    expect_burst("R2 unchanged", 32'h2040, 32'h10, 1'b0);

    // R1: training is forgotten across reset
    train3(32'h500, 32'h3000, 32'h8, "R1 train");
    do_reset();
    acc(32'h500, 32'h3020, 1'b0, 1'b1);
    expect_none("R1 forgotten");

    // R7: fill all 16 entries, promote PC0, then overflow by one
    do_reset();
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 16; i++) begin
        acc(32'h100 + 32'(i) * 4, 32'h10000 * 32'(i + 1) + 32'(r) * 32'h40, 1'b0, 1'b1);
        expect_none("R7 fill");
      end
    acc(32'h100, 32'h10000 + 3 * 32'h40, 1'b0, 1'b1);
    expect_none("R7 promote");
    acc(32'h900, 32'h9000, 1'b0, 1'b1);
    expect_none("R7 new pc");
    acc(32'h100, 32'h10000 + 4 * 32'h40, 1'b0, 1'b1);
    expect_burst("R7 promoted kept", 32'h10000 + 4 * 32'h40, 32'h40, 1'b0);
    acc(32'h108, 32'h30000 + 4 * 32'h40, 1'b0, 1'b1);
    expect_burst("R7 kept", 32'h30000 + 4 * 32'h40, 32'h40, 1'b0);
    acc(32'h104, 32'h20000 + 4 * 32'h40, 1'b0, 1'b1);
    expect_none("R7 evicted");

    // R9: back-pressure; second burst dropped for lack of room
    do_reset();
    pf_ready = 1'b0;
    train3(32'h600, 32'h4000, 32'h8, "R9 train");
    acc(32'h600, 32'h4020, 1'b0, 1'b1);
    acc(32'h600, 32'h4028, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      check(pf_valid == 1'b1, "R9 hold valid", 32'(pf_valid), 32'd1);
      check(pf_addr == 32'h4028, "R9 hold addr", pf_addr, 32'h4028);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    expect_burst("R9 first kept", 32'h4020, 32'h8, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule